// File: doc/BRIEF.md
# Correlating Two-Bit Branch Direction Predictor

This block predicts whether a conditional branch will be taken. It keeps a short global history that records whether each of the last three resolved branches was taken. Low bits of the branch address pick a table entry. The history pattern then picks one of eight prediction counters inside that entry. The prediction is the upper bit of the chosen counter. A taken prediction tells fetch to go to the branch destination. A not-taken prediction lets fetch continue with the next sequential instruction.

When a branch resolves, the pipeline presents its address and actual outcome on the update port. The counter that the current history and the address select is moved by a small state machine. The resolved outcome is then shifted into the history. The counter has four named states: STRONG_NT (0), WEAK_NT (1), WEAK_T (2) and STRONG_T (3). A taken outcome moves one state toward STRONG_T and a not-taken outcome moves one state toward STRONG_NT. Both end states saturate, and every counter resets to WEAK_NT. Setting the counter width parameter to 1 selects a one-bit variant, in which each state is NOT_TAKEN (0) or TAKEN (1) and simply follows the last outcome.

Top module: `corr_branch_predictor`

## Requirements
- R1: After reset, the history output is all zeros and every counter is in WEAK_NT (value 1), or NOT_TAKEN (value 0) in the one-bit variant, so every lookup predicts not taken.
- R2: The selected counter index is {pc[ALIGN_BITS+IDX_BITS-1:ALIGN_BITS], history}. Address bits below ALIGN_BITS and above the index field have no effect on the prediction.
- R3: `pred_taken` equals the most significant bit of the selected counter. Counter values 2 and 3 predict taken, and values 0 and 1 predict not taken.
- R4: An update with outcome taken increments the selected two-bit counter and saturates at 3. An update with outcome not taken decrements it and saturates at 0. Each update moves the counter by at most one step.
- R5: From a strong state (0 or 3), one contrary outcome does not change that counter's prediction, and a second consecutive contrary outcome does change it.
- R6: Each update shifts the outcome into history bit 0 (1 = taken) and moves older bits up by one; the oldest bit is dropped. Without an update, the history holds its value.
- R7: When an update and a lookup select the same counter in one cycle, the lookup returns the value from before the update. The new value is visible from the next cycle.
- R8: With a counter width of 1, the counter stores the last outcome of its slot, and that stored outcome is the prediction.
- R9: An update changes only the counter selected by its own address and the current history. Different history patterns for the same address keep separate counters.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| pred_pc | input | PC_W | Address of the branch being looked up |
| pred_taken | output | 1 | Combinational prediction, 1 = taken |
| upd_valid | input | 1 | A resolved branch is presented this cycle |
| upd_pc | input | PC_W | Address of the resolved branch |
| upd_taken | input | 1 | Actual outcome of the resolved branch, 1 = taken |
| glob_hist | output | HIST_BITS | Global outcome history, newest outcome in bit 0 |

## Verification
A lookup and an update can fall in the same cycle, and they can select the same counter. The bench drives both ports together in every step, sometimes with equal addresses so that the same counter is read and written. It samples the prediction after the inputs settle and before the clock edge. It judges that prediction against a bench model that is still in its pre-update state, then advances the model after the edge. Sweeps over all history patterns and all table entries, plus a long pseudo-random phase, run a two-bit instance and a one-bit instance side by side.

// File: rtl/bp_pkg.sv
package bp_pkg;
    // two-bit direction counter states, ordered so that the MSB is the prediction
    typedef enum logic [1:0] {
        STRONG_NT = 2'd0,
        WEAK_NT   = 2'd1,
        WEAK_T    = 2'd2,
        STRONG_T  = 2'd3
    } ctr_state_e;
endpackage

// File: rtl/bp_ctr_next.sv
module bp_ctr_next
    import bp_pkg::*;
#(
    parameter int CW = 2
) (
    input  logic [CW-1:0] cur,
    input  logic          taken,
    output logic [CW-1:0] nxt
);
    generate
        if (CW == 1) begin : g_onebit
            // NOT_TAKEN / TAKEN: the state follows the last outcome
            assign nxt = taken;
        end else begin : g_twobit
            ctr_state_e st, st_nx;
            assign st = ctr_state_e'(cur[1:0]);
            always_comb begin
                st_nx = st;
                unique case (st)
                    STRONG_NT: st_nx = taken ? WEAK_NT  : STRONG_NT;
                    WEAK_NT:   st_nx = taken ? WEAK_T   : STRONG_NT;
                    WEAK_T:    st_nx = taken ? STRONG_T : WEAK_NT;
                    STRONG_T:  st_nx = taken ? STRONG_T : WEAK_T;
                    default:   st_nx = WEAK_NT;
                endcase
            end
            assign nxt = CW'(st_nx);
        end
    endgenerate
endmodule

// File: rtl/bp_ghr.sv
module bp_ghr #(
    parameter int HB = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          shift_en,
    input  logic          bit_in,
    output logic [HB-1:0] hist
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        hist <= '0;
        else if (shift_en) hist <= {hist[HB-2:0], bit_in};
    end

    p_hist_newest_r6: assert property (@(posedge clk) disable iff (!rst_n)
        shift_en |=> hist[0] == $past(bit_in));
    p_hist_age_r6: assert property (@(posedge clk) disable iff (!rst_n)
        shift_en |=> hist[HB-1:1] == $past(hist[HB-2:0]));
    p_hist_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !shift_en |=> $stable(hist));
endmodule

// File: rtl/bp_counter_table.sv
module bp_counter_table #(
    parameter int AW = 7,
    parameter int CW = 2,
    parameter logic [CW-1:0] RST = '0
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] rd_idx,
    output logic [CW-1:0] rd_val,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_idx,
    output logic [CW-1:0] old_val,
    input  logic [CW-1:0] wr_val
);
    localparam int DEPTH = 1 << AW;

    logic [CW-1:0] cells [DEPTH];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) cells[i] <= RST;
        end else if (wr_en) begin
            cells[wr_idx] <= wr_val;
        end
    end

    assign rd_val  = cells[rd_idx];
    assign old_val = cells[wr_idx];

    p_commit_next_r7: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> cells[$past(wr_idx)] == $past(wr_val));
endmodule

// File: rtl/corr_branch_predictor.sv
module corr_branch_predictor #(
    parameter int PC_W       = 32,
    parameter int ALIGN_BITS = 2,
    parameter int IDX_BITS   = 4,
    parameter int HIST_BITS  = 3,
    parameter int CTR_BITS   = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [PC_W-1:0]      pred_pc,
    output logic                 pred_taken,
    input  logic                 upd_valid,
    input  logic [PC_W-1:0]      upd_pc,
    input  logic                 upd_taken,
    output logic [HIST_BITS-1:0] glob_hist
);
    localparam int TAW = IDX_BITS + HIST_BITS;
    localparam logic [CTR_BITS-1:0] CTR_RST = (CTR_BITS == 1) ? '0 : CTR_BITS'(1);
    localparam logic [CTR_BITS-1:0] CTR_MAX = '1;

    logic [TAW-1:0]      pred_idx, upd_idx;
    logic [CTR_BITS-1:0] pred_ctr, upd_old, upd_new;
    logic                unused_pc_bits;

    assign pred_idx = {pred_pc[ALIGN_BITS +: IDX_BITS], glob_hist};
    assign upd_idx  = {upd_pc[ALIGN_BITS +: IDX_BITS], glob_hist};
    assign unused_pc_bits = ^{pred_pc[ALIGN_BITS-1:0], pred_pc[PC_W-1:ALIGN_BITS+IDX_BITS],
                              upd_pc[ALIGN_BITS-1:0], upd_pc[PC_W-1:ALIGN_BITS+IDX_BITS]};

    bp_ghr #(.HB(HIST_BITS)) u_ghr (
        .clk(clk), .rst_n(rst_n), .shift_en(upd_valid), .bit_in(upd_taken), .hist(glob_hist)
    );

    bp_counter_table #(.AW(TAW), .CW(CTR_BITS), .RST(CTR_RST)) u_tbl (
        .clk(clk), .rst_n(rst_n),
        .rd_idx(pred_idx), .rd_val(pred_ctr),
        .wr_en(upd_valid), .wr_idx(upd_idx), .old_val(upd_old), .wr_val(upd_new)
    );

    bp_ctr_next #(.CW(CTR_BITS)) u_next (
        .cur(upd_old), .taken(upd_taken), .nxt(upd_new)
    );

    // prediction is the upper half of the selected counter
    assign pred_taken = pred_ctr[CTR_BITS-1];

    p_sat_hi_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_valid && upd_taken && upd_old == CTR_MAX) |-> upd_new == CTR_MAX);
    p_sat_lo_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_valid && !upd_taken && upd_old == '0) |-> upd_new == '0);
    p_one_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
        upd_valid |-> ({1'b0, upd_new} == {1'b0, upd_old}) ||
                      ({1'b0, upd_new} == {1'b0, upd_old} + 1'b1) ||
                      ({1'b0, upd_old} == {1'b0, upd_new} + 1'b1));

    generate
        if (CTR_BITS == 2) begin : g_hyst_chk
            p_hyst_r5: assert property (@(posedge clk) disable iff (!rst_n)
                (upd_valid && (upd_old == 2'd0 || upd_old == 2'd3) && upd_old[1] != upd_taken)
                |-> upd_new[1] == upd_old[1]);
        end
    endgenerate
endmodule

// File: tb/sim_corr_branch_predictor.sv
`timescale 1ns/1ps
module sim_corr_branch_predictor;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] pred_pc = '0;
    logic        upd_valid = 1'b0;
    logic [31:0] upd_pc = '0;
    logic        upd_taken = 1'b0;
    logic        pt2, pt1;
    logic [2:0]  gh2, gh1;

    int total = 0;
    int bad = 0;
    int m2 [32];
    int m1 [32];
    int mh = 0;

    always #2 clk = ~clk;

    corr_branch_predictor #(.PC_W(32), .ALIGN_BITS(2), .IDX_BITS(2), .HIST_BITS(3), .CTR_BITS(2)) u0 (
        .clk(clk), .rst_n(rst_n), .pred_pc(pred_pc), .pred_taken(pt2),
        .upd_valid(upd_valid), .upd_pc(upd_pc), .upd_taken(upd_taken), .glob_hist(gh2));

    corr_branch_predictor #(.PC_W(32), .ALIGN_BITS(2), .IDX_BITS(2), .HIST_BITS(3), .CTR_BITS(1)) u1 (
        .clk(clk), .rst_n(rst_n), .pred_pc(pred_pc), .pred_taken(pt1),
        .upd_valid(upd_valid), .upd_pc(upd_pc), .upd_taken(upd_taken), .glob_hist(gh1));

    function automatic int ix(logic [31:0] pc, int h);
        return (int'(pc[3:2]) << 3) | h;
    endfunction

    task automatic check(string req, int act, int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // drive one cycle; checks are taken before the edge, against the pre-update model
    task automatic step(logic [31:0] ppc, logic uv, logic [31:0] upc, logic tk, string tag);
        int pi, ui;
        @(negedge clk);
        pred_pc = ppc; upd_valid = uv; upd_pc = upc; upd_taken = tk;
        #1;
        pi = ix(ppc, mh);
        check({tag, " two-bit prediction R3"}, int'(pt2), (m2[pi] >= 2) ? 1 : 0);
        check({tag, " one-bit prediction R8"}, int'(pt1), m1[pi]);
        check({tag, " history R6"}, int'(gh2), mh);
        check({tag, " one-bit history R6"}, int'(gh1), mh);
        @(posedge clk);
        #0.5;
        if (uv) begin
            ui = ix(upc, mh);
            if (tk) m2[ui] = (m2[ui] == 3) ? 3 : m2[ui] + 1;
            else    m2[ui] = (m2[ui] == 0) ? 0 : m2[ui] - 1;
            m1[ui] = tk ? 1 : 0;
            mh = ((mh << 1) | (tk ? 1 : 0)) & 7;
        end
        upd_valid = 1'b0;
    endtask

    initial begin
        #(200000 * 4);
        bad++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [31:0] lfsr;
        for (int i = 0; i < 32; i++) begin m2[i] = 1; m1[i] = 0; end
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        check("R1 history after reset", int'(gh2), 0);
        check("R1 one-bit history after reset", int'(gh1), 0);
        for (int e = 0; e < 4; e++) begin
            step(32'(e << 2), 1'b0, '0, 1'b0, "R1 reset lookup");
        end

        // every history pattern, every entry, with noise in ignored address bits
        for (int h = 0; h < 8; h++) begin
            for (int b = 2; b >= 0; b--) begin
                step(32'h0000_0004, 1'b1, 32'h0000_0004 | 32'(h << 4), h[b], "R9 pattern train");
            end
            check("R6 history equals pattern", int'(gh2), h);
            for (int e = 0; e < 4; e++) begin
                step(32'hABC0_0000 | 32'(e << 2) | 32'(h & 3) | 32'(h << 8), 1'b0, '0, 1'b0, "R2 pattern lookup");
            end
        end

        // saturation: drive one slot to strong taken, history settles on all-ones
        for (int k = 0; k < 6; k++) step(32'h8, 1'b1, 32'h8, 1'b1, "R4 climb");
        check("R4 history all taken", int'(gh2), 7);
        step(32'h8, 1'b0, '0, 1'b0, "R4 saturated high");
        check("R4 saturated high predicts taken", int'(pt2), 1);

        // two contrary outcomes needed from a strong state
        step(32'h8, 1'b1, 32'h8, 1'b0, "R7 same-cycle read before write");
        for (int k = 0; k < 3; k++) step(32'h0, 1'b1, 32'h0, 1'b1, "R5 restore history");
        step(32'h8, 1'b0, '0, 1'b0, "R5 after one miss");
        check("R5 after one miss still taken", int'(pt2), 1);
        step(32'h8, 1'b1, 32'h8, 1'b0, "R7 same-cycle second miss");
        for (int k = 0; k < 3; k++) step(32'h0, 1'b1, 32'h0, 1'b1, "R5 restore history");
        step(32'h8, 1'b0, '0, 1'b0, "R5 after two misses");
        check("R5 after two misses not taken", int'(pt2), 0);

        // saturation at zero on an untouched entry slot
        for (int k = 0; k < 5; k++) step(32'hC, 1'b1, 32'hC, 1'b0, "R4 descend");
        step(32'hC, 1'b0, '0, 1'b0, "R4 saturated low");
        check("R4 saturated low predicts not taken", int'(pt2), 0);

        // pseudo-random mix of lookups and updates, sometimes to the same slot
        lfsr = 32'h1ACE_B00C;
        for (int n = 0; n < 600; n++) begin
            logic [31:0] ppc, upc;
            lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
            ppc = {lfsr[31:24], 20'h0, lfsr[3:0]};
            upc = lfsr[5] ? ppc : {lfsr[23:16], 20'h0, lfsr[9:6]};
            step(ppc, lfsr[11] | lfsr[12], upc, lfsr[13] ^ lfsr[14] ^ lfsr[2], "R7 random mix");
        end

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule